// File: doc/BRIEF.md
# I2C Interrupt Request Generator

This block turns the status flags of an I2C protocol engine into two level-sensitive interrupt lines. One line is for bus events and one is for bus errors. A three-bit enable register, reachable over a simple register bus, gates the sources:

- One bit enables the error line.
- One bit enables the event line.
- One bit also lets the transmit-empty and receive-not-empty buffer flags reach the event line.

The byte-finished flag counts only when no buffer flag is active. The wakeup flag reaches the event line through a path that needs no clock.

The block also sequences the clearing of the address-matched flag. A read of status register 1 arms a one-bit state. The next read of status register 3 consumes that state and sends a one-cycle clear pulse to the protocol engine. The clear happens whether or not the address flag was already set when the first read took place.

Top module: `i2c_irq_gen`

## Requirements
- R1: After reset the enable register reads 0x00, and both interrupt lines and the address-clear pulse are low.
- R2: A write with bus_addr equal to IEN_ADDR (0xA) loads bits 2:0 of bus_wdata into the enable register, with bit 0 = error enable, bit 1 = event enable and bit 2 = buffer enable. Bits 7:3 are ignored. A read at that address returns the three bits with zeros above them. A read at any other address returns zero.
- R3: With the event enable set, any of these flags raises evt_irq: start sent (evt_flags[0]), address matched ([1]), 10-bit header sent ([2]) or stop detected ([3]). With the event enable clear, no flag raises it.
- R4: Byte finished (evt_flags[4]) raises evt_irq only while transmit empty ([5]) and receive not empty ([6]) are both low.
- R5: Transmit empty and receive not empty raise evt_irq only when both the buffer enable and the event enable are set.
- R6: With the error enable set, any of these flags raises err_irq: bus error (err_flags[0]), arbitration lost ([1]), acknowledge failure ([2]) or overrun ([3]). With the error enable clear, err_irq stays low.
- R7: Apart from wakeup, each interrupt line is registered. It follows its qualified sources one clock edge after they change, both when it asserts and when it deasserts.
- R8: Wakeup (evt_flags[7]) drives evt_irq high without any clock edge while the event enable is set.
- R9: A status-1 read followed by a status-3 read produces a one-cycle addr_clr pulse in the cycle after the status-3 read. A status-3 read with no status-1 read since the last clear, reset or enable write produces no pulse.
- R10: A write to the enable register disarms the sequence, so a following status-3 read produces no pulse.
- R11: When status-1 and status-3 reads occur in the same cycle, the pulse depends only on the armed state held before that cycle. The status-1 read leaves the sequence armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| sr1_rd | input | 1 | Status register 1 read strobe |
| sr3_rd | input | 1 | Status register 3 read strobe |
| evt_flags | input | 8 | Event flags, bit order as in R3 to R8 |
| err_flags | input | 4 | Error flags, bit order as in R6 |
| evt_irq | output | 1 | Event interrupt line |
| err_irq | output | 1 | Error interrupt line |
| addr_clr | output | 1 | One-cycle clear of the address-matched flag |

## Verification
The assertions check the following on every cycle:
- An enable write lands exactly as written, with the reserved bits at zero.
- A clear error enable keeps the error line low.
- The buffer flags, with the buffer enable clear, never raise the event line on their own.
- An address-clear pulse always follows a status-3 read.

Only the bench scenarios can show the full truth table of the qualified sources over every enable setting, and the asynchronous wakeup path between clock edges. The same holds for the arming, disarming and same-cycle orderings of the status-read sequence.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int EVT_W = 8;
  localparam int ERR_W = 4;
  localparam int IEN_W = 3;
  // event flag bit positions
  localparam int F_START = 0;
  localparam int F_ADDR  = 1;
  localparam int F_HDR10 = 2;
  localparam int F_STOP  = 3;
  localparam int F_BYTE  = 4;
  localparam int F_TXE   = 5;
  localparam int F_RXNE  = 6;
  localparam int F_WAKE  = 7;
  // enable bit positions
  localparam int E_ERR = 0;
  localparam int E_EVT = 1;
  localparam int E_BUF = 2;
endpackage

// File: rtl/i2c_irq_enreg.sv
module i2c_irq_enreg
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IEN_ADDR = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IEN_W-1:0]  ien,
  output logic              ien_wr
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << IEN_W) - 1);

  logic [DATA_W-1:0] ien_q, ien_d;
  logic              hit, wr_en;

  always_comb begin
    hit   = (bus_addr == IEN_ADDR);
    wr_en = bus_wr && hit;
    ien_d = bus_wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ien_q <= '0;
    else if (wr_en) ien_q <= ien_d;
  end

  assign bus_rdata = (bus_rd && hit) ? ien_q : '0;
  assign ien       = ien_q[IEN_W-1:0];
  assign ien_wr    = wr_en;

  // R2: a write lands with reserved bits zero
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == IEN_ADDR) |=>
      (ien_q[IEN_W-1:0] == $past(bus_wdata[IEN_W-1:0])) && (ien_q[DATA_W-1:IEN_W] == '0));
endmodule

// File: rtl/i2c_irq_combine.sv
module i2c_irq_combine
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien,
  input  logic [EVT_W-1:0] evt_flags,
  input  logic [ERR_W-1:0] err_flags,
  output logic             evt_irq,
  output logic             err_irq
);
  logic evt_q, evt_d, err_q, err_d;
  logic buf_act, byte_ok, buf_ok, plain;

  always_comb begin
    buf_act = evt_flags[F_TXE] | evt_flags[F_RXNE];
    byte_ok = evt_flags[F_BYTE] & ~buf_act;
    buf_ok  = ien[E_BUF] & buf_act;
    plain   = evt_flags[F_START] | evt_flags[F_ADDR] | evt_flags[F_HDR10]
            | evt_flags[F_STOP]  | evt_flags[F_WAKE];
    evt_d   = ien[E_EVT] & (plain | byte_ok | buf_ok);
    err_d   = ien[E_ERR] & (|err_flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      err_q <= err_d;
    end
  end

  // wakeup bypasses the register so it works with the clock stopped
  assign evt_irq = evt_q | (ien[E_EVT] & evt_flags[F_WAKE]);
  assign err_irq = err_q;

  // R6: error line held low while its enable is clear
  a_r6_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[E_ERR] |=> !err_q);

  // R5: buffer flags alone cannot raise the event line without the buffer enable (covers R4 too)
  a_r5_buf_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[E_BUF] && evt_flags[F_STOP:F_START] == '0 && !evt_flags[F_WAKE] && buf_act) |=> !evt_q);
endmodule

// File: rtl/i2c_irq_addr_seq.sv
module i2c_irq_addr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sr1_rd,
  input  logic sr3_rd,
  input  logic disarm,
  output logic addr_clr
);
  logic armed_q, armed_d, clr_q, clr_d;

  always_comb begin
    clr_d = sr3_rd & armed_q;
    if (disarm)      armed_d = 1'b0;
    else if (sr1_rd) armed_d = 1'b1;
    else if (sr3_rd) armed_d = 1'b0;
    else             armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      clr_q   <= clr_d;
    end
  end

  assign addr_clr = clr_q;

  // R9: a clear pulse always follows a status-3 read
  a_r9_clr_after_sr3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |-> $past(sr3_rd));
endmodule

// File: rtl/i2c_irq_gen.sv
module i2c_irq_gen
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IEN_ADDR = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sr1_rd,
  input  logic              sr3_rd,
  input  logic [EVT_W-1:0]  evt_flags,
  input  logic [ERR_W-1:0]  err_flags,
  output logic              evt_irq,
  output logic              err_irq,
  output logic              addr_clr
);
  logic [IEN_W-1:0] ien;
  logic             ien_wr;

  i2c_irq_enreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IEN_ADDR(IEN_ADDR)) u_enreg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ien(ien), .ien_wr(ien_wr));

  i2c_irq_combine u_comb (
    .clk(clk), .rst_n(rst_n), .ien(ien), .evt_flags(evt_flags), .err_flags(err_flags),
    .evt_irq(evt_irq), .err_irq(err_irq));

  i2c_irq_addr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sr1_rd(sr1_rd), .sr3_rd(sr3_rd), .disarm(ien_wr),
    .addr_clr(addr_clr));
endmodule

// File: tb/tb_i2c_irq_gen.sv
module tb_i2c_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sr1_rd = 1'b0, sr3_rd = 1'b0;
  logic [7:0] evt_flags = '0;
  logic [3:0] err_flags = '0;
  logic       evt_irq, err_irq, addr_clr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_irq_gen dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ien(input logic [7:0] d);
    @(negedge clk); bus_addr = 4'hA; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1;
    chk(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  // one status read pattern, then check pulse in the following cycle
  task automatic seq(input logic s1, input logic s3, input logic exp, input string req);
    @(negedge clk); sr1_rd = s1; sr3_rd = s3;
    @(negedge clk); sr1_rd = 1'b0; sr3_rd = 1'b0;
    chk(req, {7'b0, addr_clr}, {7'b0, exp});
  endtask

  function automatic logic exp_evt(input logic [2:0] e, input logic [7:0] f);
    logic ba = f[5] | f[6];
    return e[1] & ((|f[3:0]) | f[7] | (f[4] & ~ba) | (e[2] & ba));
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 irqs", {6'b0, evt_irq, err_irq}, 8'h00);
    chk("R1 addr_clr", {7'b0, addr_clr}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd_chk(4'hA, 8'h00, "R1 ien");

    // R2 write/readback, reserved bits ignored
    wr_ien(8'hFD);
    rd_chk(4'hA, 8'h05, "R2 readback");
    rd_chk(4'h3, 8'h00, "R2 other addr");
    @(negedge clk); bus_addr = 4'h2; bus_wdata = 8'h07; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk(4'hA, 8'h05, "R2 wrong addr write");

    // R3..R6 exhaustive sweep over enables and flags
    for (int e = 0; e < 8; e++) begin
      wr_ien(8'(e));
      for (int f = 0; f < 256; f++) begin
        @(negedge clk); evt_flags = 8'(f); err_flags = 4'(f ^ (f >> 4));
        @(negedge clk);
        chk("R3/R4/R5 evt", {7'b0, evt_irq}, {7'b0, exp_evt(3'(e), 8'(f))});
        chk("R6 err", {7'b0, err_irq}, {7'b0, e[0] & (|err_flags)});
      end
    end
    evt_flags = '0; err_flags = '0;

    // R7 one-edge latency both directions
    wr_ien(8'h03);
    @(negedge clk); err_flags = 4'h4; evt_flags = 8'h01; #1;
    chk("R7 before edge", {6'b0, evt_irq, err_irq}, 8'h00);
    @(negedge clk);
    chk("R7 assert", {6'b0, evt_irq, err_irq}, 8'h03);
    err_flags = '0; evt_flags = '0; #1;
    chk("R7 hold until edge", {6'b0, evt_irq, err_irq}, 8'h03);
    @(negedge clk);
    chk("R7 deassert", {6'b0, evt_irq, err_irq}, 8'h00);

    // R8 wakeup without a clock edge
    @(posedge clk); #1; evt_flags = 8'h80; #0.5;
    chk("R8 async wake", {7'b0, evt_irq}, 8'h01);
    evt_flags = '0;
    wr_ien(8'h00);
    @(posedge clk); #1; evt_flags = 8'h80; #0.5;
    chk("R8 wake gated", {7'b0, evt_irq}, 8'h00);
    evt_flags = '0;

    // R9 sequence
    seq(1'b0, 1'b1, 1'b0, "R9 sr3 unarmed");
    seq(1'b1, 1'b0, 1'b0, "R9 sr1 no pulse");
    seq(1'b0, 1'b0, 1'b0, "R9 idle keeps armed");
    seq(1'b0, 1'b1, 1'b1, "R9 sr3 clears");
    seq(1'b0, 1'b0, 1'b0, "R9 single pulse");
    seq(1'b0, 1'b1, 1'b0, "R9 consumed");

    // R10 enable write disarms
    seq(1'b1, 1'b0, 1'b0, "R10 arm");
    wr_ien(8'h02);
    seq(1'b0, 1'b1, 1'b0, "R10 disarmed");

    // R11 same-cycle reads
    seq(1'b1, 1'b1, 1'b0, "R11 same cycle unarmed");
    seq(1'b0, 1'b1, 1'b1, "R11 left armed");
    seq(1'b1, 1'b0, 1'b0, "R11 arm");
    seq(1'b1, 1'b1, 1'b1, "R11 same cycle armed");
    seq(1'b0, 1'b1, 1'b1, "R11 rearmed");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule